// File: doc/BRIEF.md
# Metadata Address Translation Cache

This block is a small fully associative table that maps an application address to the address of its shadow metadata. Shadow metadata sits in a two-level layout. The upper address bits select a chunk, and the lower bits, scaled down by a per-monitor element granularity, select the element inside that chunk. Each entry holds one chunk: a tag, which is the upper address bits, and the chunk's base address.

A lookup request carries an application address and a granularity shift. One clock later the block raises either a hit, with the composed metadata address, or a miss. Monitoring software in user mode owns the table. After a miss it must fill the entry before it retries. When the metadata is remapped it invalidates entries, either all of them or those carrying one tag. Fills that bring a new tag replace entries in round-robin order.

Top module: `meta_xlate_cache`

## Requirements
- R1: A lookup request in cycle N gives exactly one of hit_o or miss_o in cycle N+1, for that single cycle. A cycle with no request gives neither flag in the next cycle.
- R2: A lookup hits only when a valid entry's tag equals lookup_addr_i[31:16]. Otherwise it misses.
- R3: On a hit, meta_addr_o = entry base + (lookup_addr_i[15:0] zero-extended, shifted right by gran_shift_i), taken modulo 2^32. On a miss, and when there is no response, meta_addr_o is 0.
- R4: gran_shift_i accepts every value from 0 to 7. Shift 0 gives one element per byte, and shift 7 gives one element per 128 bytes.
- R5: A fill whose tag already sits in a valid entry overwrites that entry's base, and the replacement pointer does not move. No two valid entries ever share a tag.
- R6: A fill with a new tag writes the entry at the replacement pointer, and the pointer then advances by one modulo 8. The pointer is 0 after reset, so with no flushes the ninth distinct tag filled evicts the first.
- R7: flush_all_i invalidates every entry, and later lookups miss until the next fill.
- R8: A flush by tag invalidates the entry holding that tag. Other entries are not affected.
- R9: A lookup in the same cycle as a fill or flush sees the table as it stood before that cycle's update.
- R10: A fill in the same cycle as a flush (of all entries, or of the same tag) takes effect, so the filled entry is valid afterwards.
- R11: After reset, every entry is invalid and hit_o, miss_o and meta_addr_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_addr_i | input | 32 | Application address to translate |
| gran_shift_i | input | 3 | Element granularity shift for the lookup |
| fill_valid_i | input | 1 | Fill request from software |
| fill_tag_i | input | 16 | Upper address bits of the chunk being filled |
| fill_base_i | input | 32 | Metadata chunk base address |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_tag_valid_i | input | 1 | Invalidate the entry matching flush_tag_i |
| flush_tag_i | input | 16 | Tag to invalidate |
| hit_o | output | 1 | Previous-cycle lookup hit |
| miss_o | output | 1 | Previous-cycle lookup missed |
| meta_addr_o | output | 32 | Composed metadata address on hit, else 0 |

## Verification
A lookup can fall in the same cycle as a table update: a fill, a flush of all entries, or a flush by tag. The random phase issues lookups alongside fills and flushes drawn from a small tag pool, so the same tag is often being read and written at once. Directed cases also place a fill and a lookup of the same new tag together, and a fill together with a flush. The expected response is always taken from the bench's table model before that cycle's update, and the table contents are judged by lookups in later cycles.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_LOW_W   = 16;
  localparam int unsigned DEF_SHIFT_W = 3;
  localparam int unsigned DEF_ENTRIES = 8;
endpackage

// File: rtl/mtc_rr_victim.sv
module mtc_rr_victim #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (advance_i) ptr_q <= (ptr_q == IDX_W'(N-1)) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/mtc_offset_compose.sv
module mtc_offset_compose #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LOW_W   = 16,
  parameter int unsigned SHIFT_W = 3
) (
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [LOW_W-1:0]   low_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int unsigned PAD_W = ADDR_W - LOW_W;

  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    off_ext = {{PAD_W{1'b0}}, low_i} >> shift_i;
    addr_o  = base_i + off_ext;
  end
endmodule

// File: rtl/mtc_entry_array.sv
module mtc_entry_array #(
  parameter int unsigned N      = 8,
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic              fill_valid_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [ADDR_W-1:0] fill_base_i,
  input  logic [IDX_W-1:0]  victim_i,
  input  logic              flush_all_i,
  input  logic              flush_tag_valid_i,
  input  logic [TAG_W-1:0]  flush_tag_i,
  output logic [N-1:0]      lk_match_o,
  output logic [ADDR_W-1:0] lk_base_o,
  output logic              fill_hit_o
);
  logic [N-1:0]             fill_match;
  logic [N-1:0]             we;
  logic [N-1:0][ADDR_W-1:0] masked_base;

  assign fill_hit_o = |fill_match;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic              vld_q;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] base_q;
    logic              flush_hit;

    assign lk_match_o[i]  = vld_q && (tag_q == lk_tag_i);
    assign fill_match[i]  = vld_q && (tag_q == fill_tag_i);
    assign flush_hit      = flush_all_i || (flush_tag_valid_i && vld_q && (tag_q == flush_tag_i));
    assign we[i]          = fill_valid_i &&
                            (fill_hit_o ? fill_match[i] : (victim_i == IDX_W'(i)));
    assign masked_base[i] = lk_match_o[i] ? base_q : '0;

    // fill is applied after flush, so a same-cycle fill survives
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q  <= 1'b0;
        tag_q  <= '0;
        base_q <= '0;
      end else if (we[i]) begin
        vld_q  <= 1'b1;
        tag_q  <= fill_tag_i;
        base_q <= fill_base_i;
      end else if (flush_hit) begin
        vld_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    lk_base_o = '0;
    for (int i = 0; i < N; i++) lk_base_o = lk_base_o | masked_base[i];
  end
endmodule

// File: rtl/meta_xlate_cache.sv
module meta_xlate_cache
  import mtc_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned LOW_W       = DEF_LOW_W,
  parameter int unsigned SHIFT_W     = DEF_SHIFT_W,
  parameter int unsigned NUM_ENTRIES = DEF_ENTRIES,
  localparam int unsigned TAG_W      = ADDR_W - LOW_W,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lookup_valid_i,
  input  logic [ADDR_W-1:0]  lookup_addr_i,
  input  logic [SHIFT_W-1:0] gran_shift_i,
  input  logic               fill_valid_i,
  input  logic [TAG_W-1:0]   fill_tag_i,
  input  logic [ADDR_W-1:0]  fill_base_i,
  input  logic               flush_all_i,
  input  logic               flush_tag_valid_i,
  input  logic [TAG_W-1:0]   flush_tag_i,
  output logic               hit_o,
  output logic               miss_o,
  output logic [ADDR_W-1:0]  meta_addr_o
);
  logic [NUM_ENTRIES-1:0] lk_match;
  logic [ADDR_W-1:0]      lk_base;
  logic [ADDR_W-1:0]      composed;
  logic                   fill_hit;
  logic [IDX_W-1:0]       victim_ptr;
  logic                   lk_hit;
  logic                   hit_q, miss_q;
  logic [ADDR_W-1:0]      meta_q;

  mtc_entry_array #(
    .N(NUM_ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_array (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .lk_tag_i          (lookup_addr_i[ADDR_W-1:LOW_W]),
    .fill_valid_i      (fill_valid_i),
    .fill_tag_i        (fill_tag_i),
    .fill_base_i       (fill_base_i),
    .victim_i          (victim_ptr),
    .flush_all_i       (flush_all_i),
    .flush_tag_valid_i (flush_tag_valid_i),
    .flush_tag_i       (flush_tag_i),
    .lk_match_o        (lk_match),
    .lk_base_o         (lk_base),
    .fill_hit_o        (fill_hit)
  );

  mtc_rr_victim #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (fill_valid_i && !fill_hit),
    .ptr_o     (victim_ptr)
  );

  mtc_offset_compose #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .SHIFT_W(SHIFT_W)) u_compose (
    .base_i  (lk_base),
    .low_i   (lookup_addr_i[LOW_W-1:0]),
    .shift_i (gran_shift_i),
    .addr_o  (composed)
  );

  assign lk_hit = |lk_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      miss_q <= 1'b0;
      meta_q <= '0;
    end else begin
      hit_q  <= lookup_valid_i && lk_hit;
      miss_q <= lookup_valid_i && !lk_hit;
      meta_q <= (lookup_valid_i && lk_hit) ? composed : '0;
    end
  end

  assign hit_o       = hit_q;
  assign miss_o      = miss_q;
  assign meta_addr_o = meta_q;
endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lookup_valid_i,
  input logic             fill_valid_i,
  input logic             flush_all_i,
  input logic             hit_o,
  input logic             miss_o,
  input logic             fill_hit,
  input logic [N-1:0]     lk_match,
  input logic [IDX_W-1:0] victim_ptr
);
  a_r1_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> (hit_o ^ miss_o));

  a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> (!hit_o && !miss_o));

  a_r5_unique_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));

  a_r5_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fill_valid_i || fill_hit) |=> $stable(victim_ptr));

  a_r6_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !fill_hit) |=>
      victim_ptr == (($past(victim_ptr) == IDX_W'(N-1)) ? '0 : $past(victim_ptr) + 1'b1));

  a_r7_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_all_i && !fill_valid_i) ##1 lookup_valid_i |=> miss_o);
endmodule

bind meta_xlate_cache mtc_checker #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_valid_i (lookup_valid_i),
  .fill_valid_i   (fill_valid_i),
  .flush_all_i    (flush_all_i),
  .hit_o          (hit_o),
  .miss_o         (miss_o),
  .fill_hit       (fill_hit),
  .lk_match       (lk_match),
  .victim_ptr     (victim_ptr)
);

// File: tb/tb_meta_xlate_cache.sv
`timescale 1ns/1ps
module tb_meta_xlate_cache;
  localparam int N = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lookup_valid_i = 1'b0;
  logic [31:0] lookup_addr_i = '0;
  logic [2:0]  gran_shift_i = '0;
  logic        fill_valid_i = 1'b0;
  logic [15:0] fill_tag_i = '0;
  logic [31:0] fill_base_i = '0;
  logic        flush_all_i = 1'b0;
  logic        flush_tag_valid_i = 1'b0;
  logic [15:0] flush_tag_i = '0;
  logic        hit_o, miss_o;
  logic [31:0] meta_addr_o;

  always #2.5 clk_i = ~clk_i;

  meta_xlate_cache dut (.*);

  bit          m_vld [N];
  logic [15:0] m_tag [N];
  logic [31:0] m_base [N];
  int          m_ptr;
  int          checks = 0, fails = 0;
  bit          done = 0;

  function automatic logic [31:0] exp_addr(logic [31:0] base, logic [31:0] a, logic [2:0] sh);
    return base + ({16'h0, a[15:0]} >> sh);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit lv, logic [31:0] la, logic [2:0] sh,
                      bit fv, logic [15:0] ft, logic [31:0] fb,
                      bit fa, bit ftv, logic [15:0] ftg);
    bit          eh = 0;
    logic [31:0] ea = '0;
    int          fh = -1;
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_tag[i] == la[31:16]) begin eh = 1; ea = exp_addr(m_base[i], la, sh); end
    lookup_valid_i = lv; lookup_addr_i = la; gran_shift_i = sh;
    fill_valid_i = fv; fill_tag_i = ft; fill_base_i = fb;
    flush_all_i = fa; flush_tag_valid_i = ftv; flush_tag_i = ftg;
    // model: flush first, fill last, fill match on pre-cycle state
    if (fv) for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == ft) fh = i;
    for (int i = 0; i < N; i++)
      if (fa || (ftv && m_tag[i] == ftg)) m_vld[i] = 0;
    if (fv) begin
      int idx = (fh >= 0) ? fh : m_ptr;
      m_vld[idx] = 1; m_tag[idx] = ft; m_base[idx] = fb;
      if (fh < 0) m_ptr = (m_ptr + 1) % N;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    lookup_valid_i = 0; fill_valid_i = 0; flush_all_i = 0; flush_tag_valid_i = 0;
    chk(hit_o == (lv && eh), req, "hit_o", 32'(hit_o), 32'(lv && eh));
    chk(miss_o == (lv && !eh), req, "miss_o", 32'(miss_o), 32'(lv && !eh));
    chk(meta_addr_o == ((lv && eh) ? ea : 32'h0), req, "meta_addr_o", meta_addr_o,
        (lv && eh) ? ea : 32'h0);
  endtask

  task automatic look(string req, logic [31:0] a, logic [2:0] sh);
    step(req, 1, a, sh, 0, '0, '0, 0, 0, '0);
  endtask

  task automatic fill(string req, logic [15:0] t, logic [31:0] b);
    step(req, 0, '0, '0, 1, t, b, 0, 0, '0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_base[i] = '0; end
    m_ptr = 0;
    repeat (3) @(negedge clk_i);
    // R11: reset state
    chk(hit_o == 0 && miss_o == 0, "R11", "flags in reset", {hit_o, miss_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(meta_addr_o == 0, "R11", "meta after reset", meta_addr_o, 0);
    look("R11", 32'h1234_5678, 0);
    // R1: idle cycle gives no flag
    step("R1", 0, 32'h1234_0000, 0, 0, '0, '0, 0, 0, '0);
    // R2 R3 R4: fill then lookups at shift extremes
    fill("R2", 16'h1234, 32'h8000_0000);
    look("R3", 32'h1234_FFFF, 0);
    look("R4", 32'h1234_FFFF, 7);
    look("R4", 32'h1234_0004, 2);
    look("R2", 32'h1235_0004, 2);
    fill("R3", 16'h00AA, 32'hFFFF_FFF0);
    look("R3", 32'h00AA_0100, 0);
    // R9: fill and lookup of same new tag in one cycle -> miss, then hit
    step("R9", 1, 32'h0777_0010, 1, 1, 16'h0777, 32'h0001_0000, 0, 0, '0);
    look("R9", 32'h0777_0010, 1);
    // R5: overwrite existing tag
    fill("R5", 16'h1234, 32'h4000_0000);
    look("R5", 32'h1234_0008, 3);
    // R6: fill distinct tags until the first is evicted
    for (int i = 0; i < 6; i++) fill("R6", 16'h0100 + 16'(i), 32'h0010_0000 * i);
    look("R6", 32'h1234_0000, 0);
    look("R6", 32'h00AA_0000, 0);
    look("R6", 32'h0105_0020, 0);
    // R8: flush by tag
    step("R8", 1, 32'h0101_0000, 0, 0, '0, '0, 0, 1, 16'h0101);
    look("R8", 32'h0101_0000, 0);
    look("R8", 32'h0102_0000, 0);
    // R10: fill with flush-all survives; others cleared
    step("R10", 0, '0, 0, 1, 16'h0EEE, 32'h0000_5000, 1, 0, '0);
    look("R10", 32'h0EEE_0003, 0);
    look("R7", 32'h0103_0000, 0);
    step("R10", 0, '0, 0, 1, 16'h0DDD, 32'h0000_6000, 0, 1, 16'h0DDD);
    look("R10", 32'h0DDD_0040, 4);
    // R7: flush all then lookup misses
    step("R7", 0, '0, 0, 0, '0, '0, 1, 0, '0);
    look("R7", 32'h0EEE_0000, 0);
    // random mix
    for (int k = 0; k < 4000; k++) begin
      bit lv  = ($urandom % 4) != 0;
      bit fv  = ($urandom % 3) == 0;
      bit fa  = ($urandom % 97) == 0;
      bit ftv = ($urandom % 11) == 0;
      logic [31:0] la = {16'($urandom % 12), 16'($urandom)};
      step("R2", lv, la, 3'($urandom), fv, 16'($urandom % 12), $urandom,
           fa, ftv, 16'($urandom % 12));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule